// File: doc/BRIEF.md
# Clocked Synchronous Serial Receiver

This block takes in byte frames over a clocked synchronous serial link. The bit clock comes from one of two sources. It can be produced on chip by dividing the system clock and driving it out on `sclk_o`. It can also be taken from an external pin, where it is resynchronised into the system clock domain. Each rising edge of the bit clock shifts one data bit into a shift register. When a byte is complete, it is handed over to a holding register that software reads.

A full flag shows that an unread byte is waiting. If a new frame finishes while that flag is still set, the new byte is discarded and an overrun flag is raised. The overrun condition is fatal. While the flag is set, the receiver accepts no bits, the internal clock stops, and a transmit inhibit output tells a companion transmitter not to start. Software clears each flag with its own strobe. A single enable gates both the data interrupt request and the error interrupt request.

Top module: `clk_sync_rx`

## Requirements
- R1: Bits are assembled least significant first: the first bit received lands in `rx_data_o[0]` and the eighth bit lands in `rx_data_o[7]`.
- R2: With `clk_sel_i`=0 (internal source) and the receiver running, `sclk_o` toggles every HALF_DIV system clocks, so one bit period is 2*HALF_DIV clocks. Data is sampled on the rising edge of `sclk_o`. While the receiver is not running, `sclk_o` rests high.
- R3: With `clk_sel_i`=1 (external source), `sclk_i` and `sdata_i` each pass through SYNC_STAGES flops, and a bit is taken on each detected rising edge of `sclk_i`. In this mode `sclk_o` is held high.
- R4: If a frame completes while `full_o` is 0, the byte is copied to `rx_data_o` and `full_o` becomes 1.
- R5: If a frame completes while `full_o` is 1, `ovr_o` becomes 1 and `rx_data_o` keeps its earlier value.
- R6: `rx_irq_o` is high exactly when `full_o` and `irq_en_i` are both high. `err_irq_o` is high exactly when `ovr_o` and `irq_en_i` are both high. Each request drops in the cycle after its flag is cleared.
- R7: While `ovr_o` is 1, no bit is accepted, no frame completes and `tx_inhibit_o` is 1. `ovr_o` stays set until a `clr_ovr_i` strobe arrives. After that, the next frame is assembled from a bit counter at zero.
- R8: A `clr_full_i` strobe clears `full_o`. If the strobe arrives in the same cycle as a frame completion, the completion is treated as if the flag were already clear: the byte is transferred and `full_o` stays 1.
- R9: Dropping `rx_en_i` discards a partly received frame, stops the internal clock, and leaves `full_o`, `ovr_o` and `rx_data_o` unchanged.
- R10: After reset, `rx_data_o`=0, all flags and requests are 0, `tx_inhibit_o`=0 and `sclk_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enable |
| clk_sel_i | input | 1 | Bit clock source: 0 internal divider, 1 external pin |
| sclk_i | input | 1 | External serial clock |
| sdata_i | input | 1 | Serial data |
| irq_en_i | input | 1 | Enable for both interrupt requests |
| clr_full_i | input | 1 | Strobe that clears the full flag |
| clr_ovr_i | input | 1 | Strobe that clears the overrun flag |
| sclk_o | output | 1 | Internally generated serial clock, idle high |
| rx_data_o | output | DATA_W | Received byte |
| full_o | output | 1 | Unread byte present |
| ovr_o | output | 1 | Overrun error flag |
| rx_irq_o | output | 1 | Receive data interrupt request |
| err_irq_o | output | 1 | Receive error interrupt request |
| tx_inhibit_o | output | 1 | Blocks the transmit side while an error is pending |

## Verification
The bench instantiates the block with DATA_W=8, HALF_DIV=4 and SYNC_STAGES=2. These values keep a frame to about 64 system clocks in either clock mode, so a single run fits many full frames. That run covers back-to-back overrun, frames arriving while the block is halted, and resumption after an abort. A two-stage synchroniser gives a fixed three-cycle path from an external edge to the flag update. This makes it possible to drive a clear strobe in exactly the cycle in which a frame completes.

// File: rtl/clk_sync_rx_pkg.sv
package clk_sync_rx_pkg;
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } clk_src_e;
endpackage

// File: rtl/rx_clk_unit.sv
module rx_clk_unit
  import clk_sync_rx_pkg::*;
#(
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  clk_src_e src_i,
  input  logic     sclk_ext_i,
  input  logic     sdata_i,
  output logic     sclk_o,
  output logic     rise_o,
  output logic     bit_o
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0]       div_q;
  logic                   sclk_q;
  logic [SYNC_STAGES-1:0] csync_q, dsync_q;
  logic                   cprev_q;
  logic                   int_rise, ext_rise;

  // internal divider, idle high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      sclk_q <= 1'b1;
    end else if (!run_i || src_i != SRC_INT) begin
      div_q  <= '0;
      sclk_q <= 1'b1;
    end else if (div_q == CNT_LAST) begin
      div_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // resynchronise external clock and data together to keep them aligned
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csync_q <= {SYNC_STAGES{1'b1}};
      dsync_q <= '0;
      cprev_q <= 1'b1;
    end else begin
      csync_q <= {csync_q[SYNC_STAGES-2:0], sclk_ext_i};
      dsync_q <= {dsync_q[SYNC_STAGES-2:0], sdata_i};
      cprev_q <= csync_q[SYNC_STAGES-1];
    end
  end

  assign int_rise = run_i && (src_i == SRC_INT) && (div_q == CNT_LAST) && !sclk_q;
  assign ext_rise = run_i && (src_i == SRC_EXT) && csync_q[SYNC_STAGES-1] && !cprev_q;
  assign rise_o   = int_rise | ext_rise;
  assign bit_o    = dsync_q[SYNC_STAGES-1];
  assign sclk_o   = sclk_q;

  // R2
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> sclk_o);
  // R3
  ext_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_EXT) |=> sclk_o);
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_i,
  input  logic              rise_i,
  input  logic              bit_i,
  output logic              done_o,
  output logic [DATA_W-1:0] byte_o
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_nxt;

  // lsb first: new bit enters at the top and walks down
  assign sh_nxt = {bit_i, sh_q[DATA_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (halt_i) begin
      cnt_q <= '0;
    end else if (rise_i) begin
      sh_q  <= sh_nxt;
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign done_o = rise_i && !halt_i && (cnt_q == LAST);
  assign byte_o = sh_nxt;

  // R7, R9
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> (cnt_q == '0));
  // R1
  frame_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (cnt_q == '0));
endmodule

// File: rtl/rx_flags.sv
module rx_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              clr_full_i,
  input  logic              clr_ovr_i,
  input  logic              irq_en_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              rx_irq_o,
  output logic              err_irq_o
);
  logic [DATA_W-1:0] rdr_q;
  logic              full_q, ovr_q;
  logic              full_eff;

  // a clear in the completion cycle frees the register
  assign full_eff = full_q && !clr_full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdr_q  <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (clr_full_i) full_q <= 1'b0;
      if (clr_ovr_i)  ovr_q  <= 1'b0;
      if (done_i) begin
        if (!full_eff) begin
          rdr_q  <= byte_i;
          full_q <= 1'b1;
        end else begin
          ovr_q <= 1'b1;
        end
      end
    end
  end

  assign data_o    = rdr_q;
  assign full_o    = full_q;
  assign ovr_o     = ovr_q;
  assign rx_irq_o  = full_q & irq_en_i;
  assign err_irq_o = ovr_q & irq_en_i;

  // R5
  keep_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> $stable(rdr_q));
  // R4
  full_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_q) |-> $past(done_i));
  // R7
  halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |-> !done_i);
  // R7
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !clr_ovr_i) |=> ovr_q);
endmodule

// File: rtl/clk_sync_rx.sv
module clk_sync_rx
  import clk_sync_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              clk_sel_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              irq_en_i,
  input  logic              clr_full_i,
  input  logic              clr_ovr_i,
  output logic              sclk_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              rx_irq_o,
  output logic              err_irq_o,
  output logic              tx_inhibit_o
);
  logic              halt, rise, sbit, done;
  logic [DATA_W-1:0] frame;
  clk_src_e          src;

  assign src  = clk_src_e'(clk_sel_i);
  assign halt = !rx_en_i || ovr_o;

  rx_clk_unit #(.HALF_DIV(HALF_DIV), .SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(!halt), .src_i(src),
    .sclk_ext_i(sclk_i), .sdata_i(sdata_i),
    .sclk_o(sclk_o), .rise_o(rise), .bit_o(sbit)
  );

  rx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .halt_i(halt), .rise_i(rise),
    .bit_i(sbit), .done_o(done), .byte_o(frame)
  );

  rx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done), .byte_i(frame),
    .clr_full_i(clr_full_i), .clr_ovr_i(clr_ovr_i), .irq_en_i(irq_en_i),
    .data_o(rx_data_o), .full_o(full_o), .ovr_o(ovr_o),
    .rx_irq_o(rx_irq_o), .err_irq_o(err_irq_o)
  );

  assign tx_inhibit_o = ovr_o;

  // R7
  inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> (tx_inhibit_o && !done));
endmodule

// File: tb/sim_clk_sync_rx.sv
`timescale 1ns/1ps
module sim_clk_sync_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_en = 1'b0, clk_sel = 1'b1, sclk = 1'b1, sdata = 1'b0;
  logic irq_en = 1'b1, clr_full = 1'b0, clr_ovr = 1'b0;
  logic sclk_o, full, ovr, rx_irq, err_irq, tx_inh;
  logic [7:0] data;
  int n_chk = 0, n_bad = 0;
  realtime t0, t1;

  always #10 clk = ~clk;

  clk_sync_rx #(.DATA_W(8), .HALF_DIV(4), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .clk_sel_i(clk_sel),
    .sclk_i(sclk), .sdata_i(sdata), .irq_en_i(irq_en), .clr_full_i(clr_full),
    .clr_ovr_i(clr_ovr), .sclk_o(sclk_o), .rx_data_o(data), .full_o(full),
    .ovr_o(ovr), .rx_irq_o(rx_irq), .err_irq_o(err_irq), .tx_inhibit_o(tx_inh)
  );

  localparam logic [7:0] VEC [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_ext(input logic [7:0] b, input int nbits, input bit clr_end);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); sclk = 1'b0; sdata = b[i];
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      if (i == nbits - 1 && clr_end) begin
        repeat (2) @(negedge clk);
        clr_full = 1'b1;
        @(negedge clk);
        clr_full = 1'b0;
        repeat (2) @(negedge clk);
      end else begin
        repeat (4) @(negedge clk);
      end
    end
  endtask

  task automatic pulse_full();
    @(negedge clk); clr_full = 1'b1; @(negedge clk); clr_full = 1'b0;
  endtask

  task automatic pulse_ovr();
    @(negedge clk); clr_ovr = 1'b1; @(negedge clk); clr_ovr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 data", data, 8'h00);
    check("R10 full", full, 0);
    check("R10 ovr", ovr, 0);
    check("R10 irqs", {rx_irq, err_irq}, 0);
    check("R10 inhibit", tx_inh, 0);
    check("R10 sclk_o", sclk_o, 1);

    rx_en = 1'b1;
    foreach (VEC[k]) begin
      send_ext(VEC[k], 8, 1'b0);
      check("R1 data", data, VEC[k]);
      check("R4 full", full, 1);
      check("R6 rx_irq", rx_irq, 1);
      check("R3 sclk_o held", sclk_o, 1);
      pulse_full();
      @(negedge clk);
      check("R8 cleared", full, 0);
      check("R6 rx_irq drop", rx_irq, 0);
    end

    // overrun
    send_ext(8'h11, 8, 1'b0);
    send_ext(8'h22, 8, 1'b0);
    check("R5 ovr", ovr, 1);
    check("R5 data kept", data, 8'h11);
    check("R6 err_irq", err_irq, 1);
    check("R7 inhibit", tx_inh, 1);
    send_ext(8'h33, 8, 1'b0);
    check("R7 data while halted", data, 8'h11);
    pulse_full();
    send_ext(8'h44, 8, 1'b0);
    check("R7 no frame while halted", full, 0);
    send_ext(8'hFF, 3, 1'b0);
    pulse_ovr();
    @(negedge clk);
    check("R7 ovr cleared", ovr, 0);
    check("R6 err_irq drop", err_irq, 0);
    send_ext(8'h6E, 8, 1'b0);
    check("R7 resume data", data, 8'h6E);
    check("R7 resume full", full, 1);

    // R8 clear in completion cycle
    send_ext(8'h3C, 8, 1'b1);
    check("R8 same cycle data", data, 8'h3C);
    check("R8 same cycle full", full, 1);
    check("R8 same cycle no ovr", ovr, 0);

    // R9 abort part frame, flags kept
    @(negedge clk); rx_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 full kept", full, 1);
    check("R9 data kept", data, 8'h3C);
    rx_en = 1'b1;
    pulse_full();
    send_ext(8'hFF, 3, 1'b0);
    @(negedge clk); rx_en = 1'b0;
    repeat (2) @(negedge clk); rx_en = 1'b1;
    send_ext(8'h96, 8, 1'b0);
    check("R9 realigned data", data, 8'h96);

    // R6 enable gating
    @(negedge clk); irq_en = 1'b0;
    @(negedge clk);
    check("R6 rx_irq gated", rx_irq, 0);
    irq_en = 1'b1;
    @(negedge clk);
    check("R6 rx_irq enabled", rx_irq, 1);
    pulse_full();

    // R2 internal clock
    @(negedge clk); rx_en = 1'b0; clk_sel = 1'b0;
    @(negedge clk); rx_en = 1'b1;
    @(posedge sclk_o); t0 = $realtime;
    @(posedge sclk_o); t1 = $realtime;
    check("R2 period ns", int'(t1 - t0), 160);
    @(negedge clk); rx_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R2 idle high", sclk_o, 1);
    rx_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge sclk_o); sdata = 8'hC6 >> i;
    end
    @(posedge sclk_o);
    repeat (2) @(negedge clk);
    rx_en = 1'b0;
    check("R2 internal data", data, 8'hC6);
    check("R2 internal full", full, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule